// File: doc/BRIEF.md
# I2C Multimaster Arbitration-Loss Detector

This block sits beside the controller of an I2C master and watches for the moment that master stops owning a shared bus. It looks at five separate symptoms. Two are SDA mismatches: the line reads low while the local side is letting it float high, either during an address or transmitted data bit, or during the acknowledge slot the master sends while receiving. The other three are protocol conflicts: a START request while another master holds the bus, a repeated-START request while the module acts as a slave, and a STOP on the wire that the local master never asked for. Any one of these sets a sticky flag.

The flag stays set until software writes a 1 to it. A write of 0 leaves it alone, and a new loss in the same cycle as a clear wins over the clear. An interrupt request follows the flag whenever interrupts are enabled. In the cycle the loss is seen, the block removes the local output enables for SDA and SCL and pulses a drop request that sends the controller back to idle. The enables stay off until the controller reports the idle phase.

Top module: `arb_loss_det`

## Requirements
- R1: With `is_master`=1, `sda_drive_hi`=1 and `phase` equal to 1 (address bit) or 2 (transmitted data bit), a cycle in which `scl_in` is 1 after being 0 in the previous cycle and `sda_in` is 0 sets `arb_lost` at the next clock edge.
- R2: The same SDA mismatch with `phase`=5 (acknowledge slot the master drives while receiving) sets `arb_lost` at the next clock edge.
- R3: `start_req`=1 while `bus_busy`=1 sets `arb_lost` at the next edge; `start_req` on an idle bus does not.
- R4: `rstart_req`=1 while `is_master`=0 sets `arb_lost` at the next edge; the same request as master does not.
- R5: `stop_det`=1 while `stop_req`=0 sets `arb_lost` at the next edge; a STOP the master requested does not.
- R6: No SDA comparison takes place in phases 0, 3 (received data) or 4 (acknowledge from the far side), when SCL did not rise this cycle, when `is_master`=0, or when `sda_drive_hi`=0; `arb_lost` stays 0.
- R7: Once set, `arb_lost` holds until a cycle with `clr_wr`=1 and `clr_val`=1, after which it reads 0; `clr_wr`=1 with `clr_val`=0 leaves it set.
- R8: A loss condition and a clear write in the same cycle leave `arb_lost` at 1.
- R9: `arb_irq` is 1 exactly when `arb_lost` is 1 and `irq_en` is 1.
- R10: In the cycle a loss condition is present, `drop_bus` is 1 and both `sda_oe` and `scl_oe` are 0 regardless of the requests.
- R11: After a loss, `sda_oe` and `scl_oe` stay 0 until a cycle with `phase`=0; outside that window each follows its request input.
- R12: After synchronous reset, `arb_lost`, `arb_irq` and `drop_bus` read 0 and a first high `scl_in` is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| sda_drive_hi | input | 1 | Local master is leaving SDA high for the current bit |
| phase | input | 3 | Bit phase: 0 idle, 1 address, 2 transmit data, 3 receive data, 4 remote acknowledge, 5 local acknowledge |
| is_master | input | 1 | Module is in master mode |
| bus_busy | input | 1 | Bus held by some master |
| start_req | input | 1 | Local START request |
| rstart_req | input | 1 | Local repeated-START request |
| stop_req | input | 1 | Local STOP requested or in progress |
| stop_det | input | 1 | STOP condition seen on the bus |
| clr_wr | input | 1 | Software write strobe to the flag bit |
| clr_val | input | 1 | Value written with the strobe |
| irq_en | input | 1 | Interrupt enable |
| sda_oe_req | input | 1 | Controller wants to pull SDA low |
| scl_oe_req | input | 1 | Controller wants to pull SCL low |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| arb_irq | output | 1 | Interrupt request |
| drop_bus | output | 1 | Return-to-idle pulse for the controller |
| sda_oe | output | 1 | Gated SDA pull-down enable |
| scl_oe | output | 1 | Gated SCL pull-down enable |

## Verification
The assertions take for granted that `scl_in` and `sda_in` are already free of metastability and that `phase` is held steady across each SCL high time, so a rising edge is judged against one phase only. They also assume the controller eventually reports phase 0 after a drop request, since the enable backoff only clears there. The stimulus sets every input right after a clock edge and holds it for the whole cycle, raises SCL only through a low-then-high pair of cycles, and always ends a loss scenario by returning the phase to idle.

// File: rtl/arb_loss_pkg.sv
// Shared types for the arbitration-loss detector.
// Assumes: phase codes are produced by the controller in this encoding.
package arb_loss_pkg;

    localparam int PHASE_W  = 3;
    localparam int NUM_COND = 5;
    localparam int NUM_LINES = 2;

    // Index of each loss symptom inside the condition vector.
    localparam int C_TXBIT  = 0;
    localparam int C_ACKBIT = 1;
    localparam int C_START  = 2;
    localparam int C_RSTART = 3;
    localparam int C_STOP   = 4;

    // Index of each bus line inside the enable vectors.
    localparam int L_SDA = 0;
    localparam int L_SCL = 1;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_TXDATA = 3'd2,
        PH_RXDATA = 3'd3,
        PH_TXACK  = 3'd4,
        PH_RXACK  = 3'd5
    } phase_e;

endpackage

// File: rtl/arb_cond_detect.sv
// Detects the five arbitration-loss symptoms in the current cycle.
// Assumes: scl_in/sda_in are synchronized; phase is steady while SCL is high.
module arb_cond_detect
    import arb_loss_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   scl_in,
    input  logic   sda_in,
    input  logic   sda_drive_hi,
    input  phase_e phase,
    input  logic   is_master,
    input  logic   bus_busy,
    input  logic   start_req,
    input  logic   rstart_req,
    input  logic   stop_req,
    input  logic   stop_det,
    output logic   hit
);

    logic                scl_q;
    logic                scl_rise;
    logic                sda_clash;
    logic [NUM_COND-1:0] cond;

    // Remember last SCL level; reset high so a high bus is not seen as an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_in;
    end

    // Sample point and the raw SDA disagreement while the local master transmits.
    always_comb begin
        scl_rise  = scl_in & ~scl_q;
        sda_clash = scl_rise & is_master & sda_drive_hi & ~sda_in;
    end

    // Build the symptom vector.
    always_comb begin
        cond           = '0;
        cond[C_TXBIT]  = sda_clash & ((phase == PH_ADDR) | (phase == PH_TXDATA));
        cond[C_ACKBIT] = sda_clash & (phase == PH_RXACK);
        cond[C_START]  = start_req & bus_busy;
        cond[C_RSTART] = rstart_req & ~is_master;
        cond[C_STOP]   = stop_det & ~stop_req;
    end

    // Any symptom is a loss.
    always_comb hit = |cond;

    // R6
    no_cmp_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RXDATA && !start_req && !rstart_req && !stop_det) |-> !hit);

    // R12
    no_false_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_q && scl_in) |=> scl_q);

endmodule

// File: rtl/arb_flag_reg.sv
// Sticky arbitration-lost flag with write-1-to-clear and interrupt gating.
// Assumes: clr_wr is a one-cycle software strobe carrying clr_val.
module arb_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_wr,
    input  logic clr_val,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);

    logic clr_hit;

    // Only a written 1 counts as a clear.
    always_comb clr_hit = clr_wr & clr_val;

    // Flag update: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_hit) flag_q <= 1'b0;
    end

    // Interrupt request follows the flag when enabled.
    always_comb irq = flag_q & irq_en;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(clr_wr && clr_val)) |=> flag_q);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_val && !set_i) |=> !flag_q);

endmodule

// File: rtl/arb_line_gate.sv
// Gates the controller's pull-down enables: off in the loss cycle and held
// off until the controller reports idle.
// Assumes: the controller reaches the idle phase after a drop request.
module arb_line_gate #(
    parameter int NUM_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 phase_idle,
    input  logic [NUM_LINES-1:0] oe_req,
    output logic [NUM_LINES-1:0] oe,
    output logic                 back_q
);

    // Backoff latch: set by a loss, released once the controller is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          back_q <= 1'b0;
        else if (hit)        back_q <= 1'b1;
        else if (phase_idle) back_q <= 1'b0;
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        // Per-line enable gate.
        always_comb oe[k] = oe_req[k] & ~hit & ~back_q;
    end

    // R11
    backoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (back_q && !phase_idle) |=> back_q);

endmodule

// File: rtl/arb_loss_det.sv
// Top of the arbitration-loss detector: symptom detection, sticky flag
// and bus-line release.
// Assumes: all bus inputs synchronized to clk; one software write per cycle.
module arb_loss_det
    import arb_loss_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               sda_drive_hi,
    input  logic [PHASE_W-1:0] phase,
    input  logic               is_master,
    input  logic               bus_busy,
    input  logic               start_req,
    input  logic               rstart_req,
    input  logic               stop_req,
    input  logic               stop_det,
    input  logic               clr_wr,
    input  logic               clr_val,
    input  logic               irq_en,
    input  logic               sda_oe_req,
    input  logic               scl_oe_req,
    output logic               arb_lost,
    output logic               arb_irq,
    output logic               drop_bus,
    output logic               sda_oe,
    output logic               scl_oe
);

    phase_e               phase_t;
    logic                 hit;
    logic                 back_q;
    logic [NUM_LINES-1:0] req_v;
    logic [NUM_LINES-1:0] oe_v;

    // Map the raw phase bus onto the shared type.
    always_comb phase_t = phase_e'(phase);

    // Pack and unpack the per-line enables.
    always_comb begin
        req_v        = '0;
        req_v[L_SDA] = sda_oe_req;
        req_v[L_SCL] = scl_oe_req;
        sda_oe       = oe_v[L_SDA];
        scl_oe       = oe_v[L_SCL];
    end

    arb_cond_detect u_cond (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .sda_drive_hi (sda_drive_hi),
        .phase        (phase_t),
        .is_master    (is_master),
        .bus_busy     (bus_busy),
        .start_req    (start_req),
        .rstart_req   (rstart_req),
        .stop_req     (stop_req),
        .stop_det     (stop_det),
        .hit          (hit)
    );

    arb_flag_reg u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (hit),
        .clr_wr  (clr_wr),
        .clr_val (clr_val),
        .irq_en  (irq_en),
        .flag_q  (arb_lost),
        .irq     (arb_irq)
    );

    arb_line_gate #(.NUM_LINES(NUM_LINES)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .phase_idle (phase_t == PH_IDLE),
        .oe_req     (req_v),
        .oe         (oe_v),
        .back_q     (back_q)
    );

    // Return-to-idle request in the same cycle as the loss.
    always_comb drop_bus = hit;

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_bus |-> (!sda_oe && !scl_oe));

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && bus_busy) |=> arb_lost);

    // R4
    rstart_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rstart_req && !is_master) |=> arb_lost);

    // R5
    stray_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !stop_req) |=> arb_lost);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_irq |-> (arb_lost && irq_en));

    // R11
    oe_after_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_bus && phase_t != PH_IDLE) |=> (!sda_oe && !scl_oe));

endmodule

// File: tb/tb_arb_loss_det.sv
// Bench with a behavioural reference model compared every cycle.
module tb_arb_loss_det;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl = 1'b1, sda = 1'b1, drv = 1'b0;
    logic [2:0] ph = 3'd0;
    logic master = 0, busy = 0, start = 0, rstart = 0, sreq = 0, sdet = 0;
    logic cw = 0, cv = 0, ien = 0, sda_rq = 0, scl_rq = 0;
    logic arb_lost, arb_irq, drop_bus, sda_oe, scl_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    bit m_flag = 0, m_back = 0, m_sclp = 1;

    arb_loss_det dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .sda_drive_hi(drv), .phase(ph), .is_master(master), .bus_busy(busy),
        .start_req(start), .rstart_req(rstart), .stop_req(sreq), .stop_det(sdet),
        .clr_wr(cw), .clr_val(cv), .irq_en(ien),
        .sda_oe_req(sda_rq), .scl_oe_req(scl_rq),
        .arb_lost(arb_lost), .arb_irq(arb_irq), .drop_bus(drop_bus),
        .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic quiet();
        sda = 1; drv = 0; ph = 3'd0; master = 0; busy = 0; start = 0; rstart = 0;
        sreq = 0; sdet = 0; cw = 0; cv = 0; sda_rq = 0; scl_rq = 0;
    endtask

    // One cycle: compare outputs mid-cycle, then advance the model at the edge.
    task automatic step(input string tag);
        bit rise, clash, loss, nflag, nback;
        #2;
        rise  = scl && !m_sclp;
        clash = rise && master && drv && !sda;
        loss  = (clash && (ph == 3'd1 || ph == 3'd2 || ph == 3'd5)) ||
                (start && busy) || (rstart && !master) || (sdet && !sreq);
        chk(tag,   "arb_lost", arb_lost, m_flag);
        chk("R9",  "arb_irq",  arb_irq,  m_flag && ien);
        chk("R10", "drop_bus", drop_bus, loss);
        chk("R11", "sda_oe",   sda_oe,   sda_rq && !loss && !m_back);
        chk("R11", "scl_oe",   scl_oe,   scl_rq && !loss && !m_back);
        nflag = loss ? 1'b1 : ((cw && cv) ? 1'b0 : m_flag);
        nback = loss ? 1'b1 : ((ph == 3'd0) ? 1'b0 : m_back);
        @(posedge clk);
        #1;
        m_flag = nflag; m_back = nback; m_sclp = scl;
    endtask

    // SCL low then high with SDA read back low on the high cycle.
    task automatic clash_pair(input string tag);
        scl = 0; sda = 1; step(tag);
        scl = 1; sda = 0; step(tag);
        sda = 1;
    endtask

    task automatic clear_flag();
        quiet(); cw = 1; cv = 1; step("R7");
        cw = 0; cv = 0; step("R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        quiet(); scl = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        m_flag = 0; m_back = 0; m_sclp = 1;

        // R12 reset state, SCL already high
        step("R12"); step("R12");

        // R1 address bit mismatch
        master = 1; drv = 1; ph = 3'd1; sda_rq = 1; scl_rq = 1;
        clash_pair("R1");
        step("R11");              // lines held off while not idle
        ph = 3'd0; step("R11");   // backoff released
        step("R11");
        // R7 write of 0 keeps flag
        quiet(); cw = 1; cv = 0; step("R7"); cw = 0; step("R7");
        clear_flag();

        // R1 transmitted data bit
        quiet(); master = 1; drv = 1; ph = 3'd2;
        clash_pair("R1"); ph = 3'd0; step("R1");
        clear_flag();

        // R6 no comparison in receive data / remote ack / without SCL edge
        quiet(); master = 1; drv = 1; ph = 3'd3; clash_pair("R6"); step("R6");
        ph = 3'd4; clash_pair("R6"); step("R6");
        ph = 3'd1; scl = 1; step("R6"); sda = 0; step("R6"); sda = 1; step("R6");
        ph = 3'd0; clash_pair("R6"); step("R6");
        // R6 not master, and master driving low
        quiet(); master = 0; drv = 1; ph = 3'd2; clash_pair("R6"); step("R6");
        quiet(); master = 1; drv = 0; ph = 3'd2; clash_pair("R6"); step("R6");

        // R2 acknowledge slot while receiving
        quiet(); master = 1; drv = 1; ph = 3'd5; sda_rq = 1;
        clash_pair("R2"); step("R2"); ph = 3'd0; step("R2");
        clear_flag();

        // R3 START on busy bus; no effect on idle bus
        quiet(); start = 1; busy = 0; step("R3"); start = 0; step("R3");
        start = 1; busy = 1; step("R3"); quiet(); step("R3");
        clear_flag();

        // R4 repeated START as slave; no effect as master
        quiet(); master = 1; rstart = 1; step("R4"); rstart = 0; step("R4");
        master = 0; rstart = 1; step("R4"); quiet(); step("R4");
        clear_flag();

        // R5 requested STOP harmless; stray STOP flags
        quiet(); sreq = 1; sdet = 1; step("R5"); quiet(); step("R5");
        sdet = 1; step("R5"); quiet(); step("R5");

        // R9 interrupt enable toggling with flag set
        ien = 1; step("R9"); ien = 0; step("R9"); ien = 1; step("R9");

        // R8 new loss and clear together: set wins
        quiet(); sdet = 1; cw = 1; cv = 1; step("R8");
        quiet(); step("R8");
        clear_flag(); step("R9");
        ien = 0;

        // R10/R11 loss mid-transfer with enables requested, then long hold
        quiet(); master = 1; drv = 1; ph = 3'd2; sda_rq = 1; scl_rq = 1;
        clash_pair("R10");
        for (int i = 0; i < 4; i++) step("R11");
        ph = 3'd0; step("R11"); step("R11");
        clear_flag();
        quiet(); step("R12");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule